// File: doc/BRIEF.md
# Synthesiser Divider Serial Loader

This block takes a three-wire serial stream from a host processor: a serial clock, a data line and a frame enable. It loads the three divide values of a frequency synthesiser from that stream: a 7-bit swallow (A) count, a 10-bit main (M) count and an 11-bit reference (R) count. The serial lines are brought into the block's system clock domain through a synchroniser chain. A frame starts when the enable line goes high and ends when it goes low. One data bit is captured on each rising serial clock edge inside the frame. The block counts the captured bits and, once the frame has closed, uses that count to decide which holding latches to update.

A 28-bit frame loads all three counts. A 17-bit frame updates only A and M, so that a channel change needs fewer bits while the reference divide keeps its value. Any other frame length is thrown away.

The control is a three-state machine. `ST_IDLE` waits with the enable low and holds the bit counter at zero. The transition IDLE→SHIFT is taken when the synchronised enable is high. `ST_SHIFT` captures bits. The transition SHIFT→COMMIT is taken when the enable falls. `ST_COMMIT` lasts one cycle: it updates the latches selected by the bit count and then takes COMMIT→IDLE unconditionally.

Top module: `synth_prog_loader`

## Requirements
- R1: After reset, and whenever reset is asserted, `a_val`, `m_val` and `r_val` are all zero.
- R2: For a frame of exactly 28 bits, the bits are sent most significant first: the first 7 bits become `a_val`, the next 10 bits become `m_val` and the last 11 bits become `r_val`.
- R3: For a frame of exactly 17 bits, the first 7 bits become `a_val` and the last 10 bits become `m_val`. `r_val` keeps its previous value.
- R4: In a 28-bit frame, bits 26, 27 and 28 (counted from 1) land in `r_val[2]`, `r_val[1]` and `r_val[0]`. In a 17-bit frame, bits 15, 16 and 17 land in `m_val[2]`, `m_val[1]` and `m_val[0]`.
- R5: The outputs change only in the cycle that follows the commit state. They stay unchanged while a frame is being shifted in.
- R6: A frame whose bit count is neither 17 nor 28 (for example 0, 5, 16, 18 or 27) leaves all three outputs unchanged.
- R7: The bit counter restarts from zero at the start of every frame, so a discarded frame does not shift the count of the next one.
- R8: Serial clock edges and data changes while the enable is low are not captured and do not change the outputs.
- R9: The bit counter stops at 29. Frames longer than 28 bits (for example 49 or 60 bits) are discarded and never wrap around to a valid length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock from the host; asynchronous to `clk` |
| ser_data | input | 1 | Serial data, captured on a rising `ser_clk` |
| ser_en | input | 1 | Frame enable; high while a frame is sent |
| a_val | output | 7 | Latched swallow count |
| m_val | output | 10 | Latched main count |
| r_val | output | 11 | Latched reference count |

## Verification
The hardest case to reach from the ports is a frame long enough that a counter which wraps would land back on 17 or 28. A narrow counter would then latch garbage from an over-long frame. The bench sends 49-bit and 60-bit frames, each of which would wrap to exactly one of the two valid lengths in a 5-bit counter. It checks that all three outputs keep their values. A second case that is hard to reach is a stale count: a frame abandoned after 11 bits, followed by a 17-bit frame whose 11 + 17 = 28 would be accepted as a full frame if the counter did not restart.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } ld_state_e;

endpackage

// File: rtl/spl_sync.sv
module spl_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= d_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign d_out = stg[STAGES-1];

endmodule

// File: rtl/spl_shifter.sv
module spl_shifter #(
    parameter int FULL_LEN = 28,
    parameter int CNT_MAX  = 29,
    parameter int CNT_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                accept,
    input  logic                sclk_s,
    input  logic                en_s,
    input  logic                data_s,
    output logic [FULL_LEN-1:0] shreg,
    output logic [CNT_W-1:0]    bit_cnt
);

    logic sclk_q;
    logic take_bit;

    assign take_bit = accept && en_s && sclk_s && !sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (take_bit) begin
            shreg <= {shreg[FULL_LEN-2:0], data_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (clr) begin
            bit_cnt <= '0;
        end else if (take_bit && (bit_cnt != CNT_W'(CNT_MAX))) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spl_fsm.sv
module spl_fsm
    import synth_prog_pkg::*;
#(
    parameter int A_W   = 7,
    parameter int M_W   = 10,
    parameter int R_W   = 11,
    parameter int CNT_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en_s,
    input  logic [CNT_W-1:0]       bit_cnt,
    input  logic [A_W+M_W+R_W-1:0] shreg,
    output ld_state_e              state,
    output logic [A_W-1:0]         a_val,
    output logic [M_W-1:0]         m_val,
    output logic [R_W-1:0]         r_val
);

    localparam int SHORT_LEN = A_W + M_W;
    localparam int FULL_LEN  = SHORT_LEN + R_W;

    ld_state_e state_nx;
    logic      is_short;
    logic      is_full;

    assign is_short = (bit_cnt == CNT_W'(SHORT_LEN));
    assign is_full  = (bit_cnt == CNT_W'(FULL_LEN));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (en_s)  state_nx = ST_SHIFT;
            ST_SHIFT:  if (!en_s) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_val <= '0;
            m_val <= '0;
            r_val <= '0;
        end else if (state == ST_COMMIT) begin
            if (is_full) begin
                a_val <= shreg[FULL_LEN-1 -: A_W];
                m_val <= shreg[R_W +: M_W];
                r_val <= shreg[R_W-1:0];
            end else if (is_short) begin
                a_val <= shreg[SHORT_LEN-1 -: A_W];
                m_val <= shreg[M_W-1:0];
            end
        end
    end

endmodule

// File: rtl/synth_prog_loader.sv
module synth_prog_loader
    import synth_prog_pkg::*;
#(
    parameter int A_W         = 7,
    parameter int M_W         = 10,
    parameter int R_W         = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_en,
    output logic [A_W-1:0] a_val,
    output logic [M_W-1:0] m_val,
    output logic [R_W-1:0] r_val
);

    localparam int SHORT_LEN = A_W + M_W;
    localparam int FULL_LEN  = SHORT_LEN + R_W;
    localparam int CNT_MAX   = FULL_LEN + 1;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);

    logic [2:0]          raw_in;
    logic [2:0]          sync_out;
    logic                sclk_s;
    logic                data_s;
    logic                en_s;
    ld_state_e           state;
    logic [CNT_W-1:0]    bit_cnt;
    logic [FULL_LEN-1:0] shreg;

    assign raw_in = {ser_en, ser_data, ser_clk};
    assign sclk_s = sync_out[0];
    assign data_s = sync_out[1];
    assign en_s   = sync_out[2];

    spl_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_in),
        .d_out (sync_out)
    );

    spl_shifter #(
        .FULL_LEN (FULL_LEN),
        .CNT_MAX  (CNT_MAX),
        .CNT_W    (CNT_W)
    ) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state == ST_IDLE),
        .accept  (state == ST_SHIFT),
        .sclk_s  (sclk_s),
        .en_s    (en_s),
        .data_s  (data_s),
        .shreg   (shreg),
        .bit_cnt (bit_cnt)
    );

    spl_fsm #(
        .A_W   (A_W),
        .M_W   (M_W),
        .R_W   (R_W),
        .CNT_W (CNT_W)
    ) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_s    (en_s),
        .bit_cnt (bit_cnt),
        .shreg   (shreg),
        .state   (state),
        .a_val   (a_val),
        .m_val   (m_val),
        .r_val   (r_val)
    );

endmodule

// File: rtl/synth_prog_loader_chk.sv
module synth_prog_loader_chk
    import synth_prog_pkg::*;
#(
    parameter int A_W   = 7,
    parameter int M_W   = 10,
    parameter int R_W   = 11,
    parameter int CNT_W = 5
) (
    input logic           clk,
    input logic           rst_n,
    input ld_state_e      state,
    input logic [CNT_W-1:0] bit_cnt,
    input logic [A_W-1:0] a_val,
    input logic [M_W-1:0] m_val,
    input logic [R_W-1:0] r_val
);

    localparam int SHORT_LEN = A_W + M_W;
    localparam int FULL_LEN  = SHORT_LEN + R_W;

    // R5: latches move only right after the commit state
    p_quiet_outside_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_COMMIT) |=> ($stable(a_val) && $stable(m_val) && $stable(r_val)));

    // R3: a short frame keeps the reference count
    p_ref_kept_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT && bit_cnt == CNT_W'(SHORT_LEN)) |=> $stable(r_val));

    // R6: a frame of any other length is discarded
    p_bad_len_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT && bit_cnt != CNT_W'(SHORT_LEN) && bit_cnt != CNT_W'(FULL_LEN))
        |=> ($stable(a_val) && $stable(m_val) && $stable(r_val)));

    // R7: every frame starts counting from zero
    p_count_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && $past(state) == ST_IDLE) |-> (bit_cnt == '0));

    // R9: the counter never passes one beyond the full length
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FULL_LEN + 1));

endmodule

bind synth_prog_loader synth_prog_loader_chk #(
    .A_W   (A_W),
    .M_W   (M_W),
    .R_W   (R_W),
    .CNT_W (CNT_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state),
    .bit_cnt (bit_cnt),
    .a_val   (a_val),
    .m_val   (m_val),
    .r_val   (r_val)
);

// File: tb/synth_prog_loader_tb_top.sv
module synth_prog_loader_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int WATCHDOG   = 150000;
    localparam int NVEC       = 10;

    // [69:64] bit count, [63:0] payload sent from bit (count-1) down to bit 0
    localparam logic [69:0] VEC [NVEC] = '{
        {6'd28, 64'h000000000ABCDEF1},
        {6'd17, 64'h0000000000012345},
        {6'd28, 64'h0000000000000007},
        {6'd17, 64'h0000000000000005},
        {6'd16, 64'h000000000000FFFF},
        {6'd18, 64'h000000000003FFFF},
        {6'd49, 64'h0001FFFFFFFFFFFF},
        {6'd60, 64'h0FFFFFFFFFFFFFFF},
        {6'd27, 64'h0000000007FFFFFF},
        {6'd28, 64'h0000000005A5A5A5}
    };
    localparam string TAGS [NVEC] = '{"R2", "R3", "R4", "R4", "R6", "R6",
                                      "R9", "R9", "R6", "R2"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_en = 1'b0;
    logic [6:0]  a_val;
    logic [9:0]  m_val;
    logic [10:0] r_val;

    int n_checks = 0;
    int n_fail   = 0;
    logic done = 1'b0;

    logic [6:0]  ea = '0;
    logic [9:0]  em = '0;
    logic [10:0] er = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_prog_loader dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .ser_en   (ser_en),
        .a_val    (a_val),
        .m_val    (m_val),
        .r_val    (r_val)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " a"}, 32'(a_val), 32'(ea));
        check({tag, " m"}, 32'(m_val), 32'(em));
        check({tag, " r"}, 32'(r_val), 32'(er));
    endtask

    task automatic frame_open();
        ser_clk = 1'b0;
        ser_en  = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic send_bit(input logic b);
        ser_data = b;
        wait_clk(HALF);
        ser_clk = 1'b1;
        wait_clk(HALF);
        ser_clk = 1'b0;
    endtask

    task automatic frame_close();
        wait_clk(HALF);
        ser_en = 1'b0;
        wait_clk(12);
    endtask

    task automatic send_frame(input int n, input logic [63:0] p);
        frame_open();
        for (int b = n - 1; b >= 0; b--) send_bit(p[b]);
        frame_close();
    endtask

    // model of the requirements: 28 loads all, 17 loads A and M, else nothing
    task automatic model(input int n, input logic [63:0] p);
        if (n == 28) begin
            ea = p[27:21]; em = p[20:11]; er = p[10:0];
        end else if (n == 17) begin
            ea = p[16:10]; em = p[9:0];
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        wait_clk(5);
        // R1: reset state
        check_all("R1 reset");
        rst_n = 1'b1;
        wait_clk(4);
        check_all("R1 after release");

        for (int i = 0; i < NVEC; i++) begin
            send_frame(int'(VEC[i][69:64]), VEC[i][63:0]);
            model(int'(VEC[i][69:64]), VEC[i][63:0]);
            check_all(TAGS[i]);
        end

        // R4: exact positions of the last three bits
        send_frame(28, 64'h0000000000000005);
        model(28, 64'h0000000000000005);
        check("R4 r2..r0", 32'(r_val[2:0]), 32'h5);
        send_frame(17, 64'h0000000000000003);
        model(17, 64'h0000000000000003);
        check("R4 m2..m0", 32'(m_val[2:0]), 32'h3);

        // R5: outputs steady while a frame is being shifted
        frame_open();
        for (int b = 27; b >= 18; b--) send_bit(1'b1);
        check_all("R5 mid-frame");
        for (int b = 17; b >= 0; b--) send_bit(1'b1);
        frame_close();
        model(28, 64'h000000000FFFFFFF);
        check_all("R5 after commit");

        // R8: clock and data activity with enable low
        for (int k = 0; k < 20; k++) send_bit(k[0]);
        wait_clk(12);
        check_all("R8 enable low");
        send_frame(17, 64'h0000000000000000);
        model(17, 64'h0);
        check_all("R8 next short frame");

        // R6 and R7: empty frame, then an abandoned 11-bit frame, then 17 bits
        send_frame(0, 64'h0);
        check_all("R6 empty frame");
        send_frame(11, 64'h00000000000007FF);
        check_all("R7 abandoned frame");
        send_frame(17, 64'h0000000000015555);
        model(17, 64'h0000000000015555);
        check_all("R7 count restarted");

        // R1: reset in the middle of operation
        rst_n = 1'b0;
        wait_clk(3);
        ea = '0; em = '0; er = '0;
        check_all("R1 mid-run reset");
        rst_n = 1'b1;
        wait_clk(4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule